// File: doc/BRIEF.md
# Two-Pattern Scan Delay Test Sequencer

This block sequences one two-pattern delay test on a plain scan chain that has no hold latches. The first state is shifted into the chain with the slow clock. The block then produces the second state in one of two ways. In shift mode, one more scan shift at the rated clock both forms the second state and launches the transition, so the second state is the first state moved by one bit position. In functional mode, scan enable drops for the launch edge, and the logic computes the second state from the first state and the first primary-input values. In both modes a single rated-period capture edge in normal mode latches the response, and the chain is then shifted out with the slow clock.

Each control cycle of `clk` stands for one edge that the chain will see. The outputs are a scan enable, a clock select that picks the slow clock or the rated clock for that edge, and a select that moves the primary inputs from their first-pattern to their second-pattern values at launch. A shift counter gives the position within the current load or unload. The chain length and the mode are taken when a test starts and are kept until it ends, so a test in progress cannot be changed.

Top module: `dly_pair_seq`

## Requirements
- R1: After reset, scan_en, rated_sel, pi_v2, busy, done and shift_cnt are all 0.
- R2: A start seen while idle with a nonzero chain_len L begins the load phase in the next cycle. The load phase lasts exactly L cycles, with scan_en=1, rated_sel=0, pi_v2=0, busy=1, and shift_cnt running 0,1,...,L-1.
- R3: With func_mode=0 (shift mode) sampled at start, the single cycle after the load phase is the launch, with scan_en=1, rated_sel=1, pi_v2=1 and shift_cnt=0.
- R4: With func_mode=1 (functional mode) sampled at start, the launch cycle has scan_en=0, rated_sel=1, pi_v2=1 and shift_cnt=0.
- R5: The launch is followed by exactly one capture cycle, with scan_en=0, rated_sel=1 and pi_v2=1, in both modes. rated_sel is therefore high for exactly two consecutive cycles in each test.
- R6: The capture is followed by an unload phase of exactly L cycles, with scan_en=1, rated_sel=0, pi_v2=0, busy=1, and shift_cnt running 0,...,L-1.
- R7: After the last unload cycle, done is 1 for exactly one cycle with busy=0 and all other outputs 0. The block is idle in the next cycle.
- R8: Changes to func_mode and chain_len after start has been taken have no effect on the test in progress.
- R9: A start pulse while a test is in progress is ignored. The sequence is unchanged and no second test follows.
- R10: A start with chain_len=0 is ignored, and the block stays idle with all outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock, one cycle per chain edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a test (taken only when idle) |
| func_mode | input | 1 | 0 = shift-launch, 1 = functional launch |
| chain_len | input | CW | Scan chain length L, sampled at start |
| scan_en | output | 1 | Scan enable for the edge of this cycle |
| rated_sel | output | 1 | 1 = rated clock, 0 = slow clock |
| pi_v2 | output | 1 | 1 = primary inputs carry second-pattern values |
| busy | output | 1 | A test is in progress |
| done | output | 1 | One-cycle pulse at end of unload |
| shift_cnt | output | CW | Position within the load or unload phase |

## Verification
The assertions assume that reset is applied before the first start and that chain_len stays within what the counter width can hold. They also assume that a sampled length is never zero once a test is running, which the start filter guarantees. The stimulus applies start, func_mode and chain_len only on falling clock edges. It uses lengths from 1 to the parameter maximum, and it deliberately toggles the mode, the length and start in the middle of a run, so that the assertions on the rated-clock window and on counter progression are exercised in both modes and with busy-time disturbances.

// File: rtl/dly_pair_seq.sv
module dly_pair_seq #(
  parameter int MAX_LEN = 16,
  localparam int CW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          func_mode,
  input  logic [CW-1:0] chain_len,
  output logic          scan_en,
  output logic          rated_sel,
  output logic          pi_v2,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] shift_cnt
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_LAUNCH, ST_CAPT, ST_UNLOAD, ST_DONE
  } phase_t;

  phase_t        ph;
  logic [CW-1:0] len_q;
  logic          func_q;
  logic [CW-1:0] cnt;
  logic          last_shift;

  assign last_shift = (cnt == len_q - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= ST_IDLE;
      len_q  <= '0;
      func_q <= 1'b0;
      cnt    <= '0;
    end else begin
      case (ph)
        ST_IDLE: begin
          cnt <= '0;
          if (start && chain_len != '0) begin
            ph     <= ST_LOAD;
            len_q  <= chain_len;
            func_q <= func_mode;
          end
        end
        ST_LOAD: begin
          if (last_shift) begin
            ph  <= ST_LAUNCH;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_LAUNCH: ph <= ST_CAPT;
        ST_CAPT: begin
          ph  <= ST_UNLOAD;
          cnt <= '0;
        end
        ST_UNLOAD: begin
          if (last_shift) begin
            ph  <= ST_DONE;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: ph <= ST_IDLE;
      endcase
    end
  end

  assign scan_en   = (ph == ST_LOAD) || (ph == ST_UNLOAD) || (ph == ST_LAUNCH && !func_q);
  assign rated_sel = (ph == ST_LAUNCH) || (ph == ST_CAPT);
  assign pi_v2     = rated_sel;
  assign busy      = (ph != ST_IDLE) && (ph != ST_DONE);
  assign done      = (ph == ST_DONE);
  assign shift_cnt = cnt;

  assert_load_begins_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (scan_en && !rated_sel && shift_cnt == '0));

  assert_count_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rated_sel && shift_cnt != '0) |-> (shift_cnt == $past(shift_cnt) + CW'(1)));

  assert_count_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (shift_cnt < len_q));

  assert_func_launch_no_scan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rated_sel) && func_q) |-> !scan_en);

  assert_rated_two_edges_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rated_sel) |=> (rated_sel && !scan_en));

  assert_rated_window_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rated_sel && $past(rated_sel)) |=> !rated_sel);

  assert_unload_after_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rated_sel) |-> (scan_en && busy && shift_cnt == '0));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> (!scan_en && !rated_sel && !pi_v2));

  assert_settings_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(len_q) && $stable(func_q)));

endmodule

// File: tb/sim_dly_pair_seq.sv
module sim_dly_pair_seq;
  localparam int MAX_LEN = 16;
  localparam int CW = $clog2(MAX_LEN + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          func_mode = 1'b0;
  logic [CW-1:0] chain_len = '0;
  logic          scan_en, rated_sel, pi_v2, busy, done;
  logic [CW-1:0] shift_cnt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [4:0]    flags;
    logic [CW-1:0] cnt;
    string         tag;
  } exp_t;

  exp_t q[$];

  always #5 clk = ~clk;

  dly_pair_seq #(.MAX_LEN(MAX_LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .func_mode(func_mode),
    .chain_len(chain_len), .scan_en(scan_en), .rated_sel(rated_sel),
    .pi_v2(pi_v2), .busy(busy), .done(done), .shift_cnt(shift_cnt)
  );

  function automatic logic [4:0] obs_flags();
    return {scan_en, rated_sel, pi_v2, busy, done};
  endfunction

  task automatic push(input logic [4:0] f, input int c, input string tag);
    exp_t e;
    e.flags = f;
    e.cnt = CW'(c);
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (obs_flags() !== e.flags || shift_cnt !== e.cnt) begin
        errors++;
        $display("FAIL %s: actual se/rs/pv/busy/done=%b cnt=%0d, expected %b cnt=%0d",
                 e.tag, obs_flags(), shift_cnt, e.flags, e.cnt);
      end
    end
  end

  task automatic run_test(input logic fm, input int len, input bit disturb, input string xtag);
    @(negedge clk);
    start = 1'b1;
    func_mode = fm;
    chain_len = CW'(len);
    if (len == 0) begin
      for (int i = 0; i < 3; i++) push(5'b00000, 0, "R10 zero length ignored");
    end else begin
      for (int i = 0; i < len; i++) push(5'b10010, i, {"R2 load ", xtag});
      if (fm) push(5'b01110, 0, {"R4 functional launch ", xtag});
      else    push(5'b11110, 0, {"R3 shift launch ", xtag});
      push(5'b01110, 0, {"R5 capture ", xtag});
      for (int i = 0; i < len; i++) push(5'b10010, i, {"R6 unload ", xtag});
      push(5'b00001, 0, {"R7 done pulse ", xtag});
      push(5'b00000, 0, {"R7 idle after done ", xtag});
    end
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      @(negedge clk);
      start = 1'b1;
      func_mode = ~fm;
      chain_len = CW'(len == 1 ? 5 : 1);
      @(negedge clk);
      start = 1'b0;
      func_mode = ~fm;
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    checks++;
    if (obs_flags() !== 5'b00000 || shift_cnt !== '0) begin
      errors++;
      $display("FAIL R1 reset state: actual %b cnt=%0d, expected 00000 cnt=0", obs_flags(), shift_cnt);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (obs_flags() !== 5'b00000) begin
      errors++;
      $display("FAIL R1 idle after reset: actual %b, expected 00000", obs_flags());
    end
    run_test(1'b0, 4, 1'b0, "");
    run_test(1'b1, 4, 1'b0, "");
    run_test(1'b0, 1, 1'b0, "");
    run_test(1'b1, 1, 1'b0, "");
    run_test(1'b1, 7, 1'b0, "");
    run_test(1'b0, 0, 1'b0, "");
    run_test(1'b0, MAX_LEN, 1'b1, "R8 R9 disturbed");
    run_test(1'b1, 3, 1'b1, "R8 R9 disturbed");
    run_test(1'b1, 1, 1'b1, "R8 R9 disturbed");
    run_test(1'b0, 2, 1'b0, "");
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual run still going, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule